// File: doc/BRIEF.md
# SCSI Controller Command and Interrupt Unit

This unit sits behind the byte-wide register port of a SCSI protocol controller. Software writes a command byte, and the unit decodes it into updates of three registers: the status register, the interrupt-cause register and the sequence-step register. It also drives one level-sensitive interrupt line. The line follows the interrupt bit of the status register. Reading the interrupt-cause register returns the cause and acknowledges the interrupt.

A transfer engine next to the unit signals the end of a command with a completion pulse and a status byte. If no interrupt is outstanding, the completion is reported at once. If an interrupt is already pending, the completion is held in a one-entry slot. The held completion is reported in the same clock edge as the acknowledging read, so software never loses a completion behind an unread cause.

The unit also holds a transfer count. It keeps two copies: a written copy, which is the last values software wrote, and a live copy, which is what software reads back. Setting bit 7 of a command byte loads the live copy from the written copy. A bus-reset command also emits a one-cycle request toward the bus driver. Bus phases, arbitration and target selection lie outside this unit.

Top module: `scsi_cmd_intr`

## Requirements
- R1: While `rstN` is low, and one cycle after `resetReq` is high, the unit is in its reset state. In that state every register reads 0, except configuration (offset 7), which reads 0x07. `irq` and `busResetReq` are low, and no completion is held. With the default of 3 count bytes, the offsets are: count bytes 0 to 2, command 3, status 4, cause 5, sequence step 6, configuration 7, completion byte 8.
- R2: A read of cause (offset 5) with `regWrEn` low returns the cause from before the read. After that clock edge: cause is 0, status bits 4 (terminal count) and 7 (interrupt) are 0, sequence step is 4, and `irq` is low, unless a held completion is reported in the same edge.
- R3: `irq` always equals status bit 7. Raising the interrupt while it is already set changes nothing.
- R4: A completion pulse that arrives while the interrupt is set only stores its status byte, and no register changes. The next acknowledging read returns the old cause and then reports the stored completion.
- R5: A completion report does the following: status becomes 0x93 (status phase 0b011, terminal count, interrupt), cause becomes 0x10 (bus service), sequence step 0, live count 0, and the completion byte (offset 8) takes the reported status byte.
- R6: Writes to count offsets change only the written copy. A command byte with bit 7 set loads the live copy from the written copy. With bit 7 clear, the live copy is kept.
- R7: Opcode 0x01 (flush) sets cause 0x08 and sequence step 0, and does not raise the interrupt.
- R8: Opcode 0x03 (bus reset) sets cause 0x80 and pulses `busResetReq` for one cycle. It raises the interrupt only when configuration bit 6 is 0.
- R9: Opcode 0x12 (message accepted) sets cause 0x20 and sequence step 0, and raises the interrupt.
- R10: Opcode 0x44 clears the cause without an interrupt. Opcode 0x45 clears the cause and raises the interrupt.
- R11: Opcode 0x02 (chip reset) returns the unit to the reset state of R1 and discards any held completion.
- R12: The opcode is the low 7 bits of the command byte. NOP (0x00) and unknown opcodes change nothing except the command register (offset 3) and the count load of R6.
- R13: When `regWrEn` and `regRdEn` are both high in one cycle, the write takes effect and the read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resetReq | input | 1 | Synchronous reset request from the parent |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register offset |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from current state |
| cmplValid | input | 1 | Completion pulse from the transfer engine |
| cmplStatus | input | 8 | Status byte of the completion |
| irq | output | 1 | Level interrupt |
| busResetReq | output | 1 | One-cycle bus-reset request |

## Verification
The bench targets the following corner cases, each with the fault it exposes:
- **Completion during a pending interrupt.** A unit that reports the completion straight away would overwrite the unread cause 0x20 with 0x10. A unit that forgets the held completion would leave `irq` low after the acknowledge.
- **Repeated acknowledge.** A second read must show the bus-service cause and only then drop `irq`.
- **Bus reset with the report-disable bit set.** This must still produce the request pulse and cause 0x80, but no interrupt.
- **Chip reset with a completion held.** A leaked held completion would fire on the next acknowledge.
- **Read and write in the same cycle.** A unit that lets the read acknowledge would drop `irq` here.

// File: rtl/scsi_ci_pkg.sv
package scsi_ci_pkg;

  localparam logic [6:0] OP_NOP     = 7'h00;
  localparam logic [6:0] OP_FLUSH   = 7'h01;
  localparam logic [6:0] OP_CHIPRST = 7'h02;
  localparam logic [6:0] OP_BUSRST  = 7'h03;
  localparam logic [6:0] OP_MSGACC  = 7'h12;
  localparam logic [6:0] OP_SELON   = 7'h44;
  localparam logic [6:0] OP_SELOFF  = 7'h45;

  localparam int ST_INT = 7;
  localparam int ST_TC  = 4;
  localparam logic [7:0] ST_PHASE_STATUS = 8'h03;

  localparam logic [7:0] CAUSE_FUNC   = 8'h08;
  localparam logic [7:0] CAUSE_BUSSVC = 8'h10;
  localparam logic [7:0] CAUSE_DISC   = 8'h20;
  localparam logic [7:0] CAUSE_RESET  = 8'h80;

  localparam logic [2:0] SEQ_DONE     = 3'd4;
  localparam logic [7:0] CFG_DEFAULT  = 8'h07;
  localparam int         CFG_RPT_OFF  = 6;

  typedef struct packed {
    logic       ack;
    logic       report;
    logic [7:0] reportStat;
    logic       cmdWr;
    logic       dmaLoad;
    logic       doFlush;
    logic       doBusRst;
    logic       doMsgAcc;
    logic       doSelOn;
    logic       doSelOff;
    logic       wipe;
  } ciStrobe_t;

endpackage

// File: rtl/scsi_ci_ctrl.sv
module scsi_ci_ctrl
  import scsi_ci_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int TC_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  input  logic              cmplValid,
  input  logic [7:0]        cmplStatus,
  input  logic              intBit,
  output ciStrobe_t         strobe,
  output logic              deferPend
);

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(TC_BYTES);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(TC_BYTES + 2);

  logic       deferQ, deferD;
  logic [7:0] heldQ, heldD;
  logic       isCmd, ackRd, intAfter, takeHeld, holdNew;
  logic [6:0] op;

  always_comb begin
    isCmd    = regWrEn && (regAddr == A_CMD);
    op       = regWrData[6:0];
    ackRd    = regRdEn && !regWrEn && (regAddr == A_CAUSE);
    intAfter = intBit && !ackRd;
    takeHeld = ackRd && deferQ;
    // after a held report the interrupt is set again, so a new pulse waits
    holdNew  = cmplValid && (intAfter || takeHeld);

    strobe            = '0;
    strobe.ack        = ackRd;
    strobe.report     = takeHeld || (cmplValid && !holdNew);
    strobe.reportStat = takeHeld ? heldQ : cmplStatus;
    strobe.cmdWr      = isCmd;
    strobe.dmaLoad    = isCmd && regWrData[7];
    strobe.doFlush    = isCmd && (op == OP_FLUSH);
    strobe.doBusRst   = isCmd && (op == OP_BUSRST);
    strobe.doMsgAcc   = isCmd && (op == OP_MSGACC);
    strobe.doSelOn    = isCmd && (op == OP_SELON);
    strobe.doSelOff   = isCmd && (op == OP_SELOFF);
    strobe.wipe       = resetReq || (isCmd && (op == OP_CHIPRST));

    deferD = deferQ && !takeHeld;
    heldD  = heldQ;
    if (holdNew) begin
      deferD = 1'b1;
      heldD  = cmplStatus;
    end
    if (strobe.wipe) begin
      deferD = 1'b0;
      heldD  = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      deferQ <= 1'b0;
      heldQ  <= '0;
    end else begin
      deferQ <= deferD;
      heldQ  <= heldD;
    end
  end

  assign deferPend = deferQ;

endmodule

// File: rtl/scsi_ci_regs.sv
module scsi_ci_regs
  import scsi_ci_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int TC_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ciStrobe_t         strobe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              intBit,
  output logic              busResetReq
);

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(TC_BYTES);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(TC_BYTES + 1);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(TC_BYTES + 2);
  localparam logic [ADDR_W-1:0] A_SEQ   = ADDR_W'(TC_BYTES + 3);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(TC_BYTES + 4);
  localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'(TC_BYTES + 5);

  logic [7:0] statQ, statD, causeQ, causeD, cfgQ, cfgD;
  logic [7:0] doneQ, doneD, cmdQ, cmdD;
  logic [2:0] seqQ, seqD;
  logic [TC_BYTES-1:0][7:0] tcLiveQ, tcLiveD, tcShadowQ, tcShadowD;
  logic busRstQ, busRstD;

  always_comb begin
    statD     = statQ;
    causeD    = causeQ;
    seqD      = seqQ;
    cfgD      = cfgQ;
    doneD     = doneQ;
    cmdD      = cmdQ;
    tcLiveD   = tcLiveQ;
    tcShadowD = tcShadowQ;
    busRstD   = 1'b0;

    if (strobe.ack) begin
      causeD        = '0;
      statD[ST_TC]  = 1'b0;
      statD[ST_INT] = 1'b0;
      seqD          = SEQ_DONE;
    end
    if (strobe.report) begin
      statD         = ST_PHASE_STATUS;
      statD[ST_TC]  = 1'b1;
      statD[ST_INT] = 1'b1;
      causeD        = CAUSE_BUSSVC;
      seqD          = '0;
      tcLiveD       = '0;
      doneD         = strobe.reportStat;
    end

    for (int i = 0; i < TC_BYTES; i++) begin
      if (regWrEn && (regAddr == ADDR_W'(i))) tcShadowD[i] = regWrData;
    end
    if (regWrEn && (regAddr == A_CFG)) cfgD = regWrData;

    if (strobe.cmdWr)   cmdD    = regWrData;
    if (strobe.dmaLoad) tcLiveD = tcShadowQ;
    if (strobe.doFlush) begin
      causeD = CAUSE_FUNC;
      seqD   = '0;
    end
    if (strobe.doBusRst) begin
      causeD  = CAUSE_RESET;
      busRstD = 1'b1;
      if (!cfgQ[CFG_RPT_OFF]) statD[ST_INT] = 1'b1;
    end
    if (strobe.doMsgAcc) begin
      causeD        = CAUSE_DISC;
      seqD          = '0;
      statD[ST_INT] = 1'b1;
    end
    if (strobe.doSelOn) causeD = '0;
    if (strobe.doSelOff) begin
      causeD        = '0;
      statD[ST_INT] = 1'b1;
    end

    if (strobe.wipe) begin
      statD     = '0;
      causeD    = '0;
      seqD      = '0;
      cfgD      = CFG_DEFAULT;
      doneD     = '0;
      cmdD      = '0;
      tcLiveD   = '0;
      tcShadowD = '0;
      busRstD   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ     <= '0;
      causeQ    <= '0;
      seqQ      <= '0;
      cfgQ      <= CFG_DEFAULT;
      doneQ     <= '0;
      cmdQ      <= '0;
      tcLiveQ   <= '0;
      tcShadowQ <= '0;
      busRstQ   <= 1'b0;
    end else begin
      statQ     <= statD;
      causeQ    <= causeD;
      seqQ      <= seqD;
      cfgQ      <= cfgD;
      doneQ     <= doneD;
      cmdQ      <= cmdD;
      tcLiveQ   <= tcLiveD;
      tcShadowQ <= tcShadowD;
      busRstQ   <= busRstD;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < TC_BYTES; i++) begin
      if (regAddr == ADDR_W'(i)) regRdData = tcLiveQ[i];
    end
    case (regAddr)
      A_CMD:   regRdData = cmdQ;
      A_STAT:  regRdData = statQ;
      A_CAUSE: regRdData = causeQ;
      A_SEQ:   regRdData = {5'b0, seqQ};
      A_CFG:   regRdData = cfgQ;
      A_DONE:  regRdData = doneQ;
      default: ;
    endcase
  end

  assign intBit      = statQ[ST_INT];
  assign busResetReq = busRstQ;

endmodule

// File: rtl/scsi_cmd_intr.sv
module scsi_cmd_intr
  import scsi_ci_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int TC_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetReq,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              cmplValid,
  input  logic [7:0]        cmplStatus,
  output logic              irq,
  output logic              busResetReq
);

  ciStrobe_t strobe;
  logic      intBit;
  logic      deferPend;

  scsi_ci_ctrl #(.ADDR_W(ADDR_W), .TC_BYTES(TC_BYTES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resetReq   (resetReq),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .cmplValid  (cmplValid),
    .cmplStatus (cmplStatus),
    .intBit     (intBit),
    .strobe     (strobe),
    .deferPend  (deferPend)
  );

  scsi_ci_regs #(.ADDR_W(ADDR_W), .TC_BYTES(TC_BYTES)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .intBit      (intBit),
    .busResetReq (busResetReq)
  );

  assign irq = intBit;

endmodule

// File: rtl/scsi_cmd_intr_chk.sv
module scsi_cmd_intr_chk
  import scsi_ci_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int TC_BYTES = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              resetReq,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [6:0]        cmdOp,
  input logic              cmplValid,
  input logic              irq,
  input logic              busResetReq,
  input logic              deferPend
);

  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(TC_BYTES);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(TC_BYTES + 2);

  logic wrCmd, ack;
  assign wrCmd = regWrEn && (regAddr == A_CMD) && !resetReq;
  assign ack   = regRdEn && !regWrEn && (regAddr == A_CAUSE) && !resetReq;

  AST_EXT_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !irq && !busResetReq && !deferPend);  // R1

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    ack && !deferPend && !cmplValid |=> !irq);  // R2

  AST_HELD_REPORTED: assert property (@(posedge clk) disable iff (!rstN)
    ack && deferPend |=> irq);  // R4

  AST_HELD_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    ack && deferPend && !cmplValid |=> !deferPend);  // R4

  AST_HOLD_WHEN_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid && irq && !ack && !resetReq && !(wrCmd && cmdOp == OP_CHIPRST)
    |=> deferPend && irq);  // R4

  AST_REPORT_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    cmplValid && !irq && !deferPend && !resetReq && !(wrCmd && cmdOp == OP_CHIPRST)
    |=> irq && !deferPend);  // R5

  AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd && cmdOp == OP_FLUSH && !irq && !cmplValid |=> !irq);  // R7

  AST_BUSRST_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd && cmdOp == OP_BUSRST |=> busResetReq);  // R8

  AST_BUSRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    busResetReq |=> !busResetReq);  // R8

  AST_MSGACC_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd && cmdOp == OP_MSGACC |=> irq);  // R9

  AST_SELOFF_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd && cmdOp == OP_SELOFF |=> irq);  // R10

  AST_CHIPRST_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd && cmdOp == OP_CHIPRST |=> !irq && !deferPend);  // R11

  AST_COLLIDE_NO_ACK: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regRdEn && regAddr == A_CAUSE && irq && !resetReq |=> irq);  // R13

endmodule

bind scsi_cmd_intr scsi_cmd_intr_chk #(.ADDR_W(ADDR_W), .TC_BYTES(TC_BYTES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .resetReq    (resetReq),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr),
  .cmdOp       (regWrData[6:0]),
  .cmplValid   (cmplValid),
  .irq         (irq),
  .busResetReq (busResetReq),
  .deferPend   (deferPend)
);

// File: tb/scsi_cmd_intr_bench.sv
module scsi_cmd_intr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;

  localparam logic [3:0] A_TC0 = 4'd0, A_TC1 = 4'd1, A_TC2 = 4'd2;
  localparam logic [3:0] A_CMD = 4'd3, A_STAT = 4'd4, A_CAUSE = 4'd5;
  localparam logic [3:0] A_SEQ = 4'd6, A_CFG = 4'd7, A_DONE = 4'd8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resetReq = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic cmplValid = 1'b0;
  logic [7:0] cmplStatus = '0;
  logic irq, busResetReq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_cmd_intr #(.ADDR_W(ADDR_W), .TC_BYTES(3)) u_scsi_cmd_intr (
    .clk(clk), .rstN(rstN), .resetReq(resetReq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .cmplValid(cmplValid), .cmplStatus(cmplStatus),
    .irq(irq), .busResetReq(busResetReq)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic ackRead(output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = A_CAUSE;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pulseCmpl(input logic [7:0] s);
    @(negedge clk);
    cmplValid = 1'b1; cmplStatus = s;
    @(negedge clk);
    cmplValid = 1'b0;
  endtask

  task automatic extReset();
    @(negedge clk);
    resetReq = 1'b1;
    @(negedge clk);
    resetReq = 1'b0;
  endtask

  task automatic expectRegs(input string req, input logic [7:0] st, input logic [7:0] ca, input logic [7:0] sq, input logic i);
    logic [7:0] v;
    peek(A_STAT, v);  check(req, "status", v, st);
    peek(A_CAUSE, v); check(req, "cause", v, ca);
    peek(A_SEQ, v);   check(req, "seq", v, sq);
    check(req, "irq", {7'b0, irq}, {7'b0, i});
  endtask

  task automatic testReset();
    logic [7:0] v;
    expectRegs("R1", 8'h00, 8'h00, 8'h00, 1'b0);
    peek(A_CFG, v);  check("R1", "cfg", v, 8'h07);
    peek(A_CMD, v);  check("R1", "cmd", v, 8'h00);
    peek(A_DONE, v); check("R1", "done", v, 8'h00);
    peek(A_TC1, v);  check("R1", "tc1", v, 8'h00);
    check("R1", "busResetReq", {7'b0, busResetReq}, 8'h00);
    // reset request input clears a raised state
    wr(A_CFG, 8'h5A);
    wr(A_CMD, 8'h12);
    extReset();
    expectRegs("R1", 8'h00, 8'h00, 8'h00, 1'b0);
    peek(A_CFG, v); check("R1", "cfg after resetReq", v, 8'h07);
  endtask

  task automatic testMsgAccAck();
    logic [7:0] v;
    extReset();
    wr(A_CMD, 8'h12);
    expectRegs("R9", 8'h80, 8'h20, 8'h00, 1'b1);
    ackRead(v);
    check("R2", "ack returns old cause", v, 8'h20);
    expectRegs("R2", 8'h00, 8'h00, 8'h04, 1'b0);
  endtask

  task automatic testSelection();
    extReset();
    wr(A_CMD, 8'h01);
    expectRegs("R7", 8'h00, 8'h08, 8'h00, 1'b0);
    wr(A_CMD, 8'h44);
    expectRegs("R10", 8'h00, 8'h00, 8'h00, 1'b0);
    wr(A_CMD, 8'h01);
    wr(A_CMD, 8'h45);
    expectRegs("R10", 8'h80, 8'h00, 8'h00, 1'b1);
    wr(A_CMD, 8'h45);
    expectRegs("R3", 8'h80, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic testFlushSeq();
    logic [7:0] v;
    extReset();
    wr(A_CMD, 8'h12);
    ackRead(v);
    wr(A_CMD, 8'h01);
    expectRegs("R7", 8'h00, 8'h08, 8'h00, 1'b0);
  endtask

  task automatic testBusReset();
    logic [7:0] v;
    extReset();
    wr(A_CMD, 8'h03);
    check("R8", "busResetReq pulse", {7'b0, busResetReq}, 8'h01);
    @(negedge clk);
    check("R8", "busResetReq drops", {7'b0, busResetReq}, 8'h00);
    expectRegs("R8", 8'h80, 8'h80, 8'h00, 1'b1);
    ackRead(v);
    wr(A_CFG, 8'h47);
    wr(A_CMD, 8'h03);
    check("R8", "busResetReq masked", {7'b0, busResetReq}, 8'h01);
    expectRegs("R8", 8'h00, 8'h80, 8'h04, 1'b0);
  endtask

  task automatic testImmediateCompletion();
    logic [7:0] v;
    extReset();
    wr(A_TC0, 8'h34); wr(A_TC1, 8'h12); wr(A_TC2, 8'h56);
    wr(A_CMD, 8'h80);
    peek(A_TC2, v); check("R6", "tc2 loaded", v, 8'h56);
    pulseCmpl(8'h02);
    expectRegs("R5", 8'h93, 8'h10, 8'h00, 1'b1);
    peek(A_DONE, v); check("R5", "done byte", v, 8'h02);
    peek(A_TC0, v);  check("R5", "tc0 cleared", v, 8'h00);
    ackRead(v);
    check("R2", "ack cause", v, 8'h10);
    expectRegs("R2", 8'h03, 8'h00, 8'h04, 1'b0);
  endtask

  task automatic testDeferred();
    logic [7:0] v;
    extReset();
    wr(A_CMD, 8'h12);
    pulseCmpl(8'h05);
    expectRegs("R4", 8'h80, 8'h20, 8'h00, 1'b1);
    peek(A_DONE, v); check("R4", "done not yet", v, 8'h00);
    ackRead(v);
    check("R4", "first ack cause", v, 8'h20);
    expectRegs("R4", 8'h93, 8'h10, 8'h00, 1'b1);
    peek(A_DONE, v); check("R4", "done byte", v, 8'h05);
    ackRead(v);
    check("R4", "second ack cause", v, 8'h10);
    expectRegs("R4", 8'h03, 8'h00, 8'h04, 1'b0);
  endtask

  task automatic testDmaAndUnknown();
    logic [7:0] v;
    extReset();
    wr(A_CMD, 8'h12);
    ackRead(v);
    wr(A_TC0, 8'h11); wr(A_TC1, 8'h22); wr(A_TC2, 8'h33);
    peek(A_TC1, v); check("R6", "live untouched by write", v, 8'h00);
    wr(A_CMD, 8'h00);
    peek(A_TC1, v); check("R6", "nop keeps live", v, 8'h00);
    expectRegs("R12", 8'h00, 8'h00, 8'h04, 1'b0);
    wr(A_CMD, 8'h7F);
    expectRegs("R12", 8'h00, 8'h00, 8'h04, 1'b0);
    peek(A_CMD, v); check("R12", "cmd reg", v, 8'h7F);
    wr(A_CMD, 8'h80);
    peek(A_TC0, v); check("R6", "tc0 loaded", v, 8'h11);
    peek(A_TC1, v); check("R6", "tc1 loaded", v, 8'h22);
    peek(A_TC2, v); check("R6", "tc2 loaded", v, 8'h33);
  endtask

  task automatic testChipReset();
    logic [7:0] v;
    extReset();
    wr(A_CFG, 8'h55);
    wr(A_TC0, 8'h66);
    wr(A_CMD, 8'h80);
    wr(A_CMD, 8'h12);
    pulseCmpl(8'h09);
    wr(A_CMD, 8'h02);
    expectRegs("R11", 8'h00, 8'h00, 8'h00, 1'b0);
    peek(A_CFG, v); check("R11", "cfg", v, 8'h07);
    peek(A_TC0, v); check("R11", "tc0", v, 8'h00);
    peek(A_CMD, v); check("R11", "cmd", v, 8'h00);
    ackRead(v);
    check("R11", "cause after wipe", v, 8'h00);
    check("R11", "held dropped irq", {7'b0, irq}, 8'h00);
    peek(A_DONE, v); check("R11", "done", v, 8'h00);
  endtask

  task automatic testCollision();
    extReset();
    wr(A_CMD, 8'h12);
    @(negedge clk);
    regWrEn = 1'b1; regRdEn = 1'b1; regAddr = A_CAUSE; regWrData = 8'hFF;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    expectRegs("R13", 8'h80, 8'h20, 8'h00, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMsgAccAck();
    testSelection();
    testFlushSeq();
    testBusReset();
    testImmediateCompletion();
    testDeferred();
    testDmaAndUnknown();
    testChipReset();
    testCollision();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule